// File: doc/BRIEF.md
# Write-Allocate Direct-Mapped Data Cache

This block is a small direct-mapped data cache placed between the memory stage of a pipeline and a slow main memory that delivers one word per access. The pipeline presents at most one load or store per cycle. A hit is answered in the same cycle. A miss raises a busy flag and starts a fixed-length line refill. The pipeline holds the request steady until busy drops, and the data or the store completion appears in that cycle.

Stores use write-allocate. A store that misses first refills the line and then merges its word into it. Every completed store is also offered to an external write buffer as a word address and data pair. Draining that buffer into main memory is outside this block.

Byte addresses are rebased by a fixed offset before decoding. The refill countdown pauses in any cycle in which the instruction side reports that its own refill is in progress. Two counters report how many requests arrived and how many of them hit.

Top module: `dcache_wa`

## Requirements
- R1: After reset every line is invalid, both counters read zero, busy is low and no write-buffer post is offered.
- R2: The word address is (byte address − 0x100) >> 2, taken modulo the address width. Bits [1:0] of the word address select the word in a line, bits [3:2] select one of 4 lines, and the bits above bit 3 form the tag.
- R3: A load that hits returns the stored word on rsp_data in the cycle it is presented, with rsp_busy low.
- R4: A miss raises rsp_busy in the cycle the request arrives. With no pauses, busy stays high for 13 cycles (4 words × 3 cycles + 1), and the result is delivered in the 14th cycle with busy low.
- R5: While a refill is outstanding, each cycle with icache_refill high adds exactly one cycle to the wait. A high icache_refill in the cycle the miss is detected has no effect.
- R6: A refill reads all 4 words of the line from memory through mem_addr/mem_rdata and then marks the line valid, so later accesses to any word of that line hit.
- R7: A store hit writes the word into the line and, in the same cycle, drives wbuf_valid high with wbuf_addr set to the store's word address and wbuf_data set to the stored data.
- R8: A store miss allocates and refills the line. In the completion cycle it merges its word and posts it to the write buffer using the exact word address of the store, not the line base.
- R9: access_count increases by one for each newly presented request and not for waiting cycles. hit_count increases by one for each request that hits.
- R10: A miss overwrites the tag of its line and invalidates the line when it begins. A later access to the previous tag at the same index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held while rsp_busy is high |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| icache_refill | input | 1 | Instruction-side refill in progress; pauses the countdown |
| rsp_data | output | DATA_W | Load result when served, otherwise zero |
| rsp_busy | output | 1 | Miss outstanding; the request must be held |
| mem_addr | output | ADDR_W-2 | Word address read from main memory during a refill |
| mem_rdata | input | DATA_W | Main-memory word at mem_addr |
| wbuf_valid | output | 1 | Store post offered to the write buffer |
| wbuf_addr | output | ADDR_W-2 | Word address of the posted store |
| wbuf_data | output | DATA_W | Data of the posted store |
| access_count | output | CNT_W | Number of requests presented |
| hit_count | output | CNT_W | Number of requests that hit |

## Verification
Faults in the line state show up at the ports on the next access to the affected line. A stale valid bit or tag turns an expected 14-cycle miss into a one-cycle hit, or the reverse, and that is visible as a busy length that differs from the one expected. A faulty countdown or pause shows as a completion cycle that is off by one or more on the first miss. A word captured in the wrong slot during a refill shows as a wrong rsp_data value on the first hit to that word after the refill. A mis-merged store shows as a wrong wbuf address or data in its completion cycle, or as a wrong value on the next load of that word.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  // Default rebase subtracted from every byte address before decoding.
  localparam int unsigned DC_DEF_BASE = 32'h100;

  // Full refill wait: one slot per word at the memory's per-word delay,
  // plus a single cycle of overhead.
  function automatic int unsigned dc_refill_cycles(input int unsigned words,
                                                   input int unsigned per_word);
    return words * per_word + 1;
  endfunction

endpackage

// File: rtl/dc_refill_ctrl.sv
module dc_refill_ctrl
  import dcache_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_DELAY = 3,
  parameter int unsigned LINE_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [LINE_W-1:0]             start_line_i,
  input  logic                          freeze_i,
  output logic                          pending_o,
  output logic                          done_o,
  output logic                          fill_en_o,
  output logic [$clog2(LINE_WORDS)-1:0] fill_word_o,
  output logic [LINE_W-1:0]             line_o
);

  localparam int unsigned OFF_W   = $clog2(LINE_WORDS);
  localparam int unsigned PENALTY = dc_refill_cycles(LINE_WORDS, WORD_DELAY);
  localparam int unsigned CNT_W   = $clog2(PENALTY + 1);

  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;
  logic              active;
  logic [CNT_W-1:0]  slot;

  // The countdown moves only in cycles where the instruction side is quiet.
  assign active    = pend_q && !freeze_i;
  assign done_o    = active && (cnt_q == CNT_W'(1));
  // Words are captured during the last LINE_WORDS moving cycles before done.
  assign fill_en_o = active && (cnt_q >= CNT_W'(2)) &&
                     (cnt_q <= CNT_W'(LINE_WORDS + 1));
  assign slot        = CNT_W'(LINE_WORDS + 1) - cnt_q;
  assign fill_word_o = slot[OFF_W-1:0];
  assign pending_o   = pend_q;
  assign line_o      = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      line_q <= '0;
    end else if (start_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CNT_W'(PENALTY);
      line_q <= start_line_i;
    end else if (active) begin
      if (cnt_q == CNT_W'(1)) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R5: a paused cycle leaves the countdown where it was.
  a_r5_pause_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && freeze_i) |=> $stable(cnt_q));

  // R4: an outstanding refill always has a countdown within its loaded range.
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(PENALTY)));

  // R4: a new refill is never started over an outstanding one.
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !pend_q);

  // R4: a freshly started refill is busy in the following cycle.
  a_r4_start_then_pending: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pend_q && !done_o));

endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int unsigned NLINES     = 4,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned TAG_W      = 10,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NLINES)-1:0]     lk_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] lk_off,
  input  logic [TAG_W-1:0]              lk_tag,
  output logic                          lk_hit_o,
  output logic [DATA_W-1:0]             lk_word_o,
  input  logic                          alloc_en,
  input  logic [$clog2(NLINES)-1:0]     alloc_idx,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic                          fill_en,
  input  logic [$clog2(NLINES)-1:0]     fill_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] fill_off,
  input  logic [DATA_W-1:0]             fill_data,
  input  logic                          seal_en,
  input  logic [$clog2(NLINES)-1:0]     seal_idx,
  input  logic                          wr_en,
  input  logic [$clog2(NLINES)-1:0]     wr_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_off,
  input  logic [DATA_W-1:0]             wr_data
);

  localparam int unsigned IDX_W = $clog2(NLINES);

  logic [DATA_W-1:0] words_q [NLINES][LINE_WORDS];
  logic              line_valid [NLINES];
  logic [TAG_W-1:0]  line_tag   [NLINES];

  // Word storage needs no reset; the valid bits guard it.
  always_ff @(posedge clk) begin
    if (fill_en) words_q[fill_idx][fill_off] <= fill_data;
    if (wr_en)   words_q[wr_idx][wr_off]     <= wr_data;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (alloc_en && (alloc_idx == IDX_W'(g))) begin
        v_q <= 1'b0;
        t_q <= alloc_tag;
      end else if (seal_en && (seal_idx == IDX_W'(g))) begin
        v_q <= 1'b1;
      end
    end

    assign line_valid[g] = v_q;
    assign line_tag[g]   = t_q;

    // R10: starting a miss invalidates the line, so a half-filled line never hits.
    a_r10_alloc_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && (alloc_idx == IDX_W'(g))) |=> !v_q);

    // R6: completing a refill leaves the line valid.
    a_r6_seal_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (seal_en && (seal_idx == IDX_W'(g))) |=> v_q);
  end

  assign lk_hit_o  = line_valid[lk_idx] && (line_tag[lk_idx] == lk_tag);
  assign lk_word_o = words_q[lk_idx][lk_off];

endmodule

// File: rtl/dcache_wa.sv
module dcache_wa
  import dcache_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NLINES     = 4,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_DELAY = 3,
  parameter int unsigned BASE       = DC_DEF_BASE,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              icache_refill,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_busy,
  output logic [ADDR_W-3:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wbuf_valid,
  output logic [ADDR_W-3:0] wbuf_addr,
  output logic [DATA_W-1:0] wbuf_data,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  hit_count
);

  localparam int unsigned WA_W   = ADDR_W - 2;
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W  = $clog2(NLINES);
  localparam int unsigned TAG_W  = WA_W - OFF_W - IDX_W;
  localparam int unsigned LINE_W = WA_W - OFF_W;

  // ---- address arithmetic ----
  function automatic logic [WA_W-1:0] to_word(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] d;
    d = a - ADDR_W'(BASE);
    return d[ADDR_W-1:2];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [WA_W-1:0] w);
    return w[OFF_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [WA_W-1:0] w);
    return w[OFF_W+IDX_W-1:OFF_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [WA_W-1:0] w);
    return w[WA_W-1:OFF_W+IDX_W];
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [WA_W-1:0] w);
    return w[WA_W-1:OFF_W];
  endfunction

  // ---- named internal events ----
  logic [WA_W-1:0]   req_word;
  logic              pending;
  logic              refill_done;
  logic              fill_en;
  logic [OFF_W-1:0]  fill_word;
  logic [LINE_W-1:0] refill_line;
  logic              hit_raw;
  logic [DATA_W-1:0] hit_word;
  logic              new_req;
  logic              lookup_hit;
  logic              miss_start;
  logic              serve;
  logic              store_commit;
  logic [CNT_W-1:0]  access_q;
  logic [CNT_W-1:0]  hit_q;

  assign req_word     = to_word(req_addr);
  assign new_req      = req_valid && !pending;
  assign lookup_hit   = new_req && hit_raw;
  assign miss_start   = new_req && !hit_raw;
  // The request is held while busy, so completion serves it directly.
  assign serve        = lookup_hit || refill_done;
  assign store_commit = serve && req_we;

  dc_refill_ctrl #(
    .LINE_WORDS (LINE_WORDS),
    .WORD_DELAY (WORD_DELAY),
    .LINE_W     (LINE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (miss_start),
    .start_line_i (line_of(req_word)),
    .freeze_i     (icache_refill),
    .pending_o    (pending),
    .done_o       (refill_done),
    .fill_en_o    (fill_en),
    .fill_word_o  (fill_word),
    .line_o       (refill_line)
  );

  dc_line_store #(
    .NLINES     (NLINES),
    .LINE_WORDS (LINE_WORDS),
    .TAG_W      (TAG_W),
    .DATA_W     (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (idx_of(req_word)),
    .lk_off    (off_of(req_word)),
    .lk_tag    (tag_of(req_word)),
    .lk_hit_o  (hit_raw),
    .lk_word_o (hit_word),
    .alloc_en  (miss_start),
    .alloc_idx (idx_of(req_word)),
    .alloc_tag (tag_of(req_word)),
    .fill_en   (fill_en),
    .fill_idx  (refill_line[IDX_W-1:0]),
    .fill_off  (fill_word),
    .fill_data (mem_rdata),
    .seal_en   (refill_done),
    .seal_idx  (refill_line[IDX_W-1:0]),
    .wr_en     (store_commit),
    .wr_idx    (idx_of(req_word)),
    .wr_off    (off_of(req_word)),
    .wr_data   (req_wdata)
  );

  // ---- responses ----
  assign rsp_busy   = miss_start || (pending && !refill_done);
  assign rsp_data   = (serve && !req_we) ? hit_word : '0;
  assign mem_addr   = {refill_line, fill_word};
  assign wbuf_valid = store_commit;
  assign wbuf_addr  = req_word;
  assign wbuf_data  = req_wdata;

  // ---- statistics ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_q <= '0;
      hit_q    <= '0;
    end else begin
      if (new_req)    access_q <= access_q + CNT_W'(1);
      if (lookup_hit) hit_q    <= hit_q + CNT_W'(1);
    end
  end

  assign access_count = access_q;
  assign hit_count    = hit_q;

  // R9: hits never outnumber accesses.
  a_r9_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= access_count);

  // R9: the access count moves by at most one per cycle.
  a_r9_access_step: assert property (@(posedge clk) disable iff (!rst_n)
    (access_count == $past(access_count)) ||
    (access_count == $past(access_count) + CNT_W'(1)));

  // R7: a post to the write buffer happens only for a store that is not waiting.
  a_r7_post_only_served_store: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_valid |-> (req_we && !rsp_busy));

  // R4: waiting cycles are never counted as new accesses.
  a_r4_wait_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !refill_done) |=> (access_count == $past(access_count)));

endmodule

// File: tb/sim_dcache_wa.sv
module sim_dcache_wa;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_valid = 1'b0;
  logic        rq_we = 1'b0;
  logic [15:0] rq_addr = '0;
  logic [31:0] rq_wd = '0;
  logic        icr = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_busy;
  logic [13:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        wbuf_valid;
  logic [13:0] wbuf_addr;
  logic [31:0] wbuf_data;
  logic [15:0] access_count;
  logic [15:0] hit_count;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit          m_valid [4];
  int          m_tag   [4];
  logic [31:0] m_data  [4][4];
  bit          m_pend = 0;
  int          m_left = 0;
  int          m_acc = 0;
  int          m_hit = 0;
  int          n_acc = 0;
  int          n_hit = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input int wa);
    return 32'hC0DE0000 ^ (32'(wa) * 32'h00010101);
  endfunction

  assign mem_rdata = memf(int'(mem_addr));

  dcache_wa u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (rq_valid),
    .req_we       (rq_we),
    .req_addr     (rq_addr),
    .req_wdata    (rq_wd),
    .icache_refill(icr),
    .rsp_data     (rsp_data),
    .rsp_busy     (rsp_busy),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .wbuf_valid   (wbuf_valid),
    .wbuf_addr    (wbuf_addr),
    .wbuf_data    (wbuf_data),
    .access_count (access_count),
    .hit_count    (hit_count)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int word_of(input logic [15:0] a);
    return int'((a - 16'h0100) & 16'hFFFF) >> 2;
  endfunction

  // One clock: compare outputs mid-cycle, then advance the reference model.
  task automatic tick();
    int wa, off, idx, tg, base;
    bit hit, done, e_busy, e_wb;
    logic [31:0] e_data;
    #2;
    wa = word_of(rq_addr);
    off = wa & 3; idx = (wa >> 2) & 3; tg = wa >> 4; base = wa & ~3;
    hit = 0; done = 0; e_busy = 0; e_wb = 0; e_data = '0;
    if (m_pend) begin
      done = !icr && (m_left == 1);
      e_busy = !done;
      if (done) begin
        for (int k = 0; k < 4; k++) m_data[idx][k] = memf(base + k);
        if (!rq_we) e_data = m_data[idx][off];
        e_wb = rq_we;
      end
    end else if (rq_valid) begin
      hit = m_valid[idx] && (m_tag[idx] == tg);
      e_busy = !hit;
      if (hit && !rq_we) e_data = m_data[idx][off];
      e_wb = hit && rq_we;
    end
    chk(rsp_busy == e_busy, cur_req, "busy", rsp_busy, e_busy);
    chk(rsp_data == e_data, cur_req, "rsp_data", rsp_data, e_data);
    chk(wbuf_valid == e_wb, cur_req, "wbuf_valid", wbuf_valid, e_wb);
    if (e_wb) begin
      chk(wbuf_addr == 14'(wa), cur_req, "wbuf_addr", wbuf_addr, wa);
      chk(wbuf_data == rq_wd, cur_req, "wbuf_data", wbuf_data, rq_wd);
    end
    chk(access_count == 16'(m_acc), cur_req, "access_count", access_count, m_acc);
    chk(hit_count == 16'(m_hit), cur_req, "hit_count", hit_count, m_hit);
    @(posedge clk);
    if (m_pend) begin
      if (done) begin
        m_valid[idx] = 1;
        if (rq_we) m_data[idx][off] = rq_wd;
        m_pend = 0;
      end else if (!icr) begin
        m_left--;
      end
    end else if (rq_valid) begin
      m_acc++;
      if (hit) begin
        m_hit++;
        if (rq_we) m_data[idx][off] = rq_wd;
      end else begin
        m_pend = 1; m_left = 13; m_valid[idx] = 0; m_tag[idx] = tg;
      end
    end
    @(negedge clk);
  endtask

  // Present a request and hold it until busy drops; pause cycles are counted
  // from the request's first cycle.
  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                        input int pz_from, input int pz_n,
                        output int ncyc, output logic [31:0] dout);
    bit was_busy;
    ncyc = 0; dout = '0;
    n_acc++;
    for (int k = 0; k < 200; k++) begin
      rq_valid = 1'b1; rq_we = we; rq_addr = a; rq_wd = wd;
      icr = (k >= pz_from) && (k < pz_from + pz_n);
      #1;
      was_busy = rsp_busy;
      dout = rsp_data;
      #0;
      tick();
      ncyc = k + 1;
      if (!was_busy) break;
    end
    if (ncyc == 1) n_hit++;
    rq_valid = 1'b0; rq_we = 1'b0; icr = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int nc;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin m_valid[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    #2;
    chk(rsp_busy == 1'b0, "R1", "busy after reset", rsp_busy, 0);
    chk(wbuf_valid == 1'b0, "R1", "wbuf after reset", wbuf_valid, 0);
    chk(access_count == 16'd0, "R1", "access after reset", access_count, 0);
    chk(hit_count == 16'd0, "R1", "hits after reset", hit_count, 0);
    @(negedge clk);
    tick();

    // R4 / R2: cold miss with no pause, word 2
    cur_req = "R4";
    access(0, 16'h0108, '0, 99, 0, nc, d);
    chk(nc == 14, "R4", "cold miss cycles", nc, 14);
    chk(d == memf(2), "R2", "mapped word 2", d, memf(2));

    // R6 / R3: other words of the filled line hit
    cur_req = "R6";
    access(0, 16'h010C, '0, 99, 0, nc, d);
    chk(nc == 1, "R6", "hit after refill", nc, 1);
    chk(d == memf(3), "R6", "word 3 data", d, memf(3));
    cur_req = "R3";
    access(0, 16'h0100, '0, 99, 0, nc, d);
    chk(nc == 1, "R3", "read hit latency", nc, 1);
    chk(d == memf(0), "R3", "word 0 data", d, memf(0));

    // R5: four pause cycles during a refill of line 1
    cur_req = "R5";
    access(0, 16'h0114, '0, 3, 4, nc, d);
    chk(nc == 18, "R5", "paused miss cycles", nc, 18);
    chk(d == memf(5), "R5", "word 5 data", d, memf(5));

    // R5: pause in the detect cycle is ignored, one pause after it counts
    access(0, 16'h0120, '0, 0, 2, nc, d);
    chk(nc == 15, "R5", "pause at detect cycle", nc, 15);
    chk(d == memf(8), "R5", "word 8 data", d, memf(8));

    // R7: store hit then load back
    cur_req = "R7";
    access(1, 16'h0104, 32'hDEADBEEF, 99, 0, nc, d);
    chk(nc == 1, "R7", "store hit latency", nc, 1);
    access(0, 16'h0104, '0, 99, 0, nc, d);
    chk(d == 32'hDEADBEEF, "R7", "merged store readback", d, 32'hDEADBEEF);

    // R10 / R2: same index, different tag
    cur_req = "R10";
    access(0, 16'h0140, '0, 99, 0, nc, d);
    chk(nc == 14, "R10", "conflict miss", nc, 14);
    chk(d == memf(16), "R2", "word 16 data", d, memf(16));
    access(0, 16'h0104, '0, 99, 0, nc, d);
    chk(nc == 14, "R10", "evicted tag misses", nc, 14);
    chk(d == memf(1), "R10", "refetched word 1", d, memf(1));

    // R8: store miss with pauses, exact word address posted at completion
    cur_req = "R8";
    access(1, 16'h0138, 32'h12345678, 1, 3, nc, d);
    chk(nc == 17, "R8", "store miss cycles", nc, 17);
    access(0, 16'h0138, '0, 99, 0, nc, d);
    chk(nc == 1 && d == 32'h12345678, "R8", "allocated store data", d, 32'h12345678);
    cur_req = "R6";
    access(0, 16'h013C, '0, 99, 0, nc, d);
    chk(d == memf(15), "R6", "neighbour word after allocate", d, memf(15));

    // R9: totals
    cur_req = "R9";
    tick();
    chk(access_count == 16'(n_acc), "R9", "access total", access_count, n_acc);
    chk(hit_count == 16'(n_hit), "R9", "hit total", hit_count, n_hit);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule